// File: doc/BRIEF.md
# Split-Access Control and Status Word

This block is one 32-bit register that a host CPU bus and on-chip logic share. The upper half of the word holds status that the on-chip logic drives. The CPU can read this half but cannot change it. The lower half holds control bits that the CPU reads and writes. A full-word read at the register's single offset returns both halves together. A full-word write changes only the control half. The status bits in the written word are dropped.

One control bit is a data-ready flag. The CPU writes a new control value with the flag set. The on-chip logic picks up the value and pulses an acknowledge, which clears only the flag. This tells the CPU that the value has been taken. If the CPU write and the acknowledge land in the same cycle, the write decides the flag, so a fresh notice is never lost. Reads have a fixed latency of one cycle: the data comes back registered, together with a valid strobe.

Top module: `mixreg_csr`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears the control half, the status half, the ready flag, `cpu_rvalid` and `cpu_rdata` to zero.
- R2: A read at offset 0x040 raises `cpu_rvalid` for exactly one cycle, on the cycle after the read. In that cycle `cpu_rdata` carries the status half in bits 31:16 and the control half in bits 15:0.
- R3: A write at offset 0x040 stores `cpu_wdata[15:0]` into the control half and shows it on `fab_ctrl` from the next cycle. `cpu_wdata[31:16]` is discarded.
- R4: The status half takes the value of `fab_status` on every clock edge, so a read returns the status seen one cycle before the read. A CPU write never alters the status half.
- R5: Reads and writes whose address bits 11:2 differ from those of 0x040 have no effect: no `cpu_rvalid`, no change to the control half. Address bits 1:0 are not decoded.
- R6: The ready flag is control bit 15 and is also driven on `fab_ready`. A CPU write sets it with a 1 in `cpu_wdata[15]` and clears it with a 0.
- R7: A one-cycle pulse on `fab_ack` clears only the ready flag. Control bits 14:0 keep their values.
- R8: When a CPU write to the register and `fab_ack` fall in the same cycle, the written value wins, including the ready flag. A written 1 stays set.
- R9: When a read and a write to the register fall in the same cycle, the read returns the contents from before the write.
- R10: `fab_ack` while the ready flag is already clear leaves the whole control half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 12 | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 32 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after the read |
| fab_status | input | 16 | Status from the on-chip logic |
| fab_ack | input | 1 | Acknowledge: clears the ready flag |
| fab_ctrl | output | 16 | Current control half |
| fab_ready | output | 1 | Ready flag (control bit 15) |

## Verification
The bench writes all-ones and patterned words and then reads them back. A design that let the upper half through would return the written bits in place of the status. The bench lines up a write with an acknowledge in the same cycle. A design that gave priority to the clear would drop the new-data notice. It also checks that the acknowledge leaves bits 14:0 untouched, which catches a design that clears the whole half. The bench issues a read and a write in the same cycle and expects the old value, and it expects a status one cycle old. Both checks catch off-by-one latency. Accesses to a neighbouring word must do nothing, which exposes a decoder that compares too few address bits.

// File: rtl/mixreg_csr_pkg.sv
package mixreg_csr_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic [HALF_W-1:0] ctrl;
        logic [HALF_W-1:0] stat;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
    } csr_state_t;
endpackage

// File: rtl/mixreg_csr_decode.sv
module mixreg_csr_decode #(
    parameter int ADDR_W     = 12,
    parameter int LSB_SKIP   = 2,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h040
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    generate
        if (LSB_SKIP > 0) begin : g_word
            assign match = (addr[ADDR_W-1:LSB_SKIP] == REG_OFFSET[ADDR_W-1:LSB_SKIP]);
        end else begin : g_byte
            assign match = (addr == REG_OFFSET);
        end
    endgenerate

    assign wr_hit = wr & match;
    assign rd_hit = rd & match;
endmodule

// File: rtl/mixreg_csr_ctrl.sv
module mixreg_csr_ctrl #(
    parameter int HALF_W    = 16,
    parameter int READY_BIT = 15
) (
    input  logic [HALF_W-1:0] ctrl_q,
    input  logic              wr_hit,
    input  logic [HALF_W-1:0] wdata_lo,
    input  logic              ack,
    output logic [HALF_W-1:0] ctrl_d
);
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_hit) begin
            // CPU write decides every bit, the flag included.
            ctrl_d = wdata_lo;
        end else if (ack) begin
            ctrl_d[READY_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/mixreg_csr.sv
module mixreg_csr
    import mixreg_csr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int LSB_SKIP  = 2,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h040,
    parameter int READY_BIT = HALF_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    input  logic [HALF_W-1:0] fab_status,
    input  logic              fab_ack,
    output logic [HALF_W-1:0] fab_ctrl,
    output logic              fab_ready
);
    csr_state_t        state_d, state_q;
    logic              wr_hit, rd_hit;
    logic [HALF_W-1:0] ctrl_next;

    mixreg_csr_decode #(
        .ADDR_W    (ADDR_W),
        .LSB_SKIP  (LSB_SKIP),
        .REG_OFFSET(REG_OFFSET)
    ) u_decode (
        .addr  (cpu_addr),
        .wr    (cpu_wr),
        .rd    (cpu_rd),
        .wr_hit(wr_hit),
        .rd_hit(rd_hit)
    );

    // Only the low half of the write word reaches storage.
    mixreg_csr_ctrl #(
        .HALF_W   (HALF_W),
        .READY_BIT(READY_BIT)
    ) u_ctrl (
        .ctrl_q  (state_q.ctrl),
        .wr_hit  (wr_hit),
        .wdata_lo(cpu_wdata[HALF_W-1:0]),
        .ack     (fab_ack),
        .ctrl_d  (ctrl_next)
    );

    always_comb begin
        state_d        = state_q;
        state_d.ctrl   = ctrl_next;
        state_d.stat   = fab_status;
        state_d.rvalid = rd_hit;
        if (rd_hit) begin
            state_d.rdata = {state_q.stat, state_q.ctrl};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cpu_rdata  = state_q.rdata;
    assign cpu_rvalid = state_q.rvalid;
    assign fab_ctrl   = state_q.ctrl;
    assign fab_ready  = state_q.ctrl[READY_BIT];
endmodule

// File: rtl/mixreg_csr_chk.sv
module mixreg_csr_chk #(
    parameter int HALF_W    = 16,
    parameter int READY_BIT = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_hit,
    input logic              rd_hit,
    input logic [31:0]       cpu_wdata,
    input logic [31:0]       cpu_rdata,
    input logic              cpu_rvalid,
    input logic [HALF_W-1:0] fab_status,
    input logic              fab_ack,
    input logic [HALF_W-1:0] fab_ctrl,
    input logic              fab_ready
);
    // R2: strobe one cycle after a decoded read
    p_rvalid_lat_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_hit) && !$past(rst)) |-> cpu_rvalid);
    p_rvalid_none_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_hit) |-> !cpu_rvalid);

    // R4: returned status is the input from two edges before
    p_stat_age_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_rvalid && !$past(rst, 2)) |-> (cpu_rdata[31:16] == $past(fab_status, 2)));

    // R3 / R8: a write sets the control half, whatever the acknowledge does
    p_wr_store_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_hit) && !$past(rst)) |-> (fab_ctrl == $past(cpu_wdata[HALF_W-1:0])));
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_hit && cpu_wdata[READY_BIT] && fab_ack) && !$past(rst)) |-> fab_ready);

    // R7: an acknowledge with no write clears the flag and keeps the other bits
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(fab_ack && !wr_hit) && !$past(rst)) |->
            (!fab_ready && fab_ctrl[READY_BIT-1:0] == $past(fab_ctrl[READY_BIT-1:0])));

    // R5: with no write and no acknowledge the control half holds
    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!wr_hit && !fab_ack) && !$past(rst)) |-> $stable(fab_ctrl));
endmodule

bind mixreg_csr mixreg_csr_chk #(
    .HALF_W   (mixreg_csr_pkg::HALF_W),
    .READY_BIT(READY_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_rvalid(cpu_rvalid),
    .fab_status(fab_status),
    .fab_ack   (fab_ack),
    .fab_ctrl  (fab_ctrl),
    .fab_ready (fab_ready)
);

// File: tb/mixreg_csr_tb.sv
module mixreg_csr_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] OFS = 12'h040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic [31:0] cpu_rdata;
    logic        cpu_rvalid;
    logic [15:0] fab_status = '0;
    logic        fab_ack = 1'b0;
    logic [15:0] fab_ctrl;
    logic        fab_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mixreg_csr u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .fab_status(fab_status), .fab_ack(fab_ack),
        .fab_ctrl(fab_ctrl), .fab_ready(fab_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drives at a negedge and returns at the next negedge.
    task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input logic r, input logic ack);
        cpu_addr = a; cpu_wr = w; cpu_wdata = d; cpu_rd = r; fab_ack = ack;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0; fab_ack = 1'b0;
    endtask

    task automatic t_reset;
        fab_status = 16'hBEEF;
        cpu_wdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R1 ctrl", {16'h0, fab_ctrl}, 32'h0);
        chk("R1 ready", {31'h0, fab_ready}, 32'h0);
        chk("R1 rvalid", {31'h0, cpu_rvalid}, 32'h0);
        chk("R1 rdata", cpu_rdata, 32'h0);
        rst = 1'b0;
        fab_status = 16'h0;
        @(negedge clk);
    endtask

    task automatic t_write_mask;
        cyc(OFS, 1'b1, 32'hFFFF_1234, 1'b0, 1'b0);
        chk("R3 ctrl", {16'h0, fab_ctrl}, 32'h0000_1234);
        cyc(OFS, 1'b0, 32'h0, 1'b1, 1'b0);
        chk("R2 rvalid", {31'h0, cpu_rvalid}, 32'h1);
        chk("R3 upper masked", cpu_rdata, 32'h0000_1234);
        @(negedge clk);
        chk("R2 strobe one cycle", {31'h0, cpu_rvalid}, 32'h0);
    endtask

    task automatic t_status;
        fab_status = 16'hA5C3;
        @(negedge clk);
        cyc(OFS, 1'b1, 32'h5A5A_7777, 1'b0, 1'b0);
        cyc(OFS, 1'b0, 32'h0, 1'b1, 1'b0);
        chk("R4 status + R2 word", cpu_rdata, 32'hA5C3_7777);
        // The status changes in the same cycle as the read: the old value is expected.
        fab_status = 16'h0F0F;
        cyc(OFS, 1'b0, 32'h0, 1'b1, 1'b0);
        chk("R4 one-cycle-old status", cpu_rdata, 32'hA5C3_7777);
        cyc(OFS, 1'b0, 32'h0, 1'b1, 1'b0);
        chk("R4 new status", cpu_rdata, 32'h0F0F_7777);
    endtask

    task automatic t_other_addr;
        cyc(12'h044, 1'b1, 32'h0000_0001, 1'b0, 1'b0);
        chk("R5 write elsewhere", {16'h0, fab_ctrl}, 32'h0000_7777);
        cyc(12'h03C, 1'b0, 32'h0, 1'b1, 1'b0);
        chk("R5 no rvalid elsewhere", {31'h0, cpu_rvalid}, 32'h0);
        cyc(12'h043, 1'b1, 32'h0000_0042, 1'b0, 1'b0);
        chk("R5 low bits not decoded", {16'h0, fab_ctrl}, 32'h0000_0042);
    endtask

    task automatic t_handshake;
        cyc(OFS, 1'b1, 32'h0000_9ABC, 1'b0, 1'b0);
        chk("R6 flag set", {31'h0, fab_ready}, 32'h1);
        cyc(OFS, 1'b0, 32'h0, 1'b0, 1'b1);
        chk("R7 flag cleared", {31'h0, fab_ready}, 32'h0);
        chk("R7 other bits kept", {16'h0, fab_ctrl}, 32'h0000_1ABC);
        cyc(OFS, 1'b0, 32'h0, 1'b0, 1'b1);
        chk("R10 idle ack", {16'h0, fab_ctrl}, 32'h0000_1ABC);
        cyc(OFS, 1'b1, 32'h0000_8001, 1'b0, 1'b0);
        cyc(OFS, 1'b1, 32'h0000_0001, 1'b0, 1'b0);
        chk("R6 flag cleared by CPU", {31'h0, fab_ready}, 32'h0);
    endtask

    task automatic t_set_wins;
        cyc(OFS, 1'b1, 32'h0000_8000, 1'b0, 1'b0);
        cyc(OFS, 1'b1, 32'h0000_C3C3, 1'b0, 1'b1);
        chk("R8 set wins", {16'h0, fab_ctrl}, 32'h0000_C3C3);
    endtask

    task automatic t_rw_same;
        fab_status = 16'h1111;
        @(negedge clk);
        cyc(OFS, 1'b1, 32'h0000_2222, 1'b1, 1'b0);
        chk("R9 old value", cpu_rdata, 32'h1111_C3C3);
        cyc(OFS, 1'b0, 32'h0, 1'b1, 1'b0);
        chk("R9 new value after", cpu_rdata, 32'h1111_2222);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write_mask();
        t_status();
        t_other_addr();
        t_handshake();
        t_set_wins();
        t_rw_same();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule